// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes the load addresses of one warp, 32 lanes that each carry a byte address and an active bit. It reduces them to the set of distinct aligned memory chunks that the active lanes touch. It then sends one bus request per chunk, one request per cycle, in ascending address order.

A mode bit is captured with the warp and picks the chunk size. In caching mode a chunk is a 128-byte line. In non-caching mode a chunk is a 32-byte segment. The warp input and the request output each use a valid/ready handshake. The block accepts a warp only when it is idle. While it works, it tags each outgoing request with its index within the warp. When the last request has been accepted, it pulses `done` together with the request count and the total bytes requested.

Top module: `coal_warp_coalescer`

## Requirements
- R1: With `warp_mode`=0 (caching), every request address is an active lane's address with bits [6:0] cleared, and `req_bytes` is 128.
- R2: With `warp_mode`=1 (non-caching), every request address is an active lane's address with bits [4:0] cleared, and `req_bytes` is 32.
- R3: Each distinct chunk touched by an active lane is requested exactly once. 32 consecutive words from a 128-byte boundary give 1 request in caching mode and 4 in non-caching mode. The same words offset by 4 bytes give 2 and 5. Lanes that all name one word give 1 request in either mode.
- R4: The requests of one warp leave in strictly ascending address order.
- R5: A lane whose active bit is 0 adds no request. A warp with no active lane issues no request and still gives a `done` pulse with a count of 0.
- R6: `warp_ready` is 1 only while idle. After a warp is accepted, no further warp is taken until the cycle after the `done` pulse.
- R7: While `req_valid` is 1 and `req_ready` is 0, the request stays valid and `req_addr` does not change.
- R8: `req_seq` gives the index of the current request within its warp, starting at 0. `done` is high for one cycle, in the cycle after the last request handshake. With it, `done_count` equals the number of requests issued and `done_bytes` equals that count times the chunk size.
- R9: Reordering the lane addresses across lanes does not change the requests issued.
- R10: After reset, `warp_ready`=1, `req_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| warp_valid | input | 1 | A warp is offered |
| warp_ready | output | 1 | The block is idle and takes the warp |
| warp_mode | input | 1 | 0 = 128-byte lines, 1 = 32-byte segments |
| warp_active | input | LANES | Per-lane active bits |
| warp_addr | input | LANES*AW | Lane byte addresses, lane i at bits [i*AW +: AW] |
| req_valid | output | 1 | A chunk request is offered |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | AW | Aligned chunk address |
| req_bytes | output | 8 | Chunk size in bytes |
| req_seq | output | CNT_W | Index of this request within the warp |
| done | output | 1 | One-cycle pulse when the warp is finished |
| done_count | output | CNT_W | Requests issued for the warp |
| done_bytes | output | CNT_W+7 | Bytes requested for the warp |

## Verification
The directed warps cover several cases. Aligned consecutive words separate line granularity from segment granularity, since they give 1 request against 4. Shifting the same words by one word checks that chunks are counted across a boundary, giving 2 against 5. A broadcast warp, where every lane names one word, and a reversed lane order show whether duplicate removal depends on lane position. Warps that are partly active or fully inactive, some with stray addresses on the inactive lanes, show whether the active bits gate chunk creation. Random warps clustered in a small window mix duplicates, random masks and random backpressure, so that the ascending order and the holding of a stalled request are tried under stalls.

// File: rtl/coal_pkg.sv
// Shared definitions for the warp coalescer.
// Assumes: chunk sizes are powers of two, line size >= segment size.
package coal_pkg;
    typedef enum logic {
        GRAN_LINE    = 1'b0,
        GRAN_SEGMENT = 1'b1
    } gran_mode_e;

    localparam int LINE_BYTES = 128;
    localparam int SEG_BYTES  = 32;
    localparam int LINE_SH    = $clog2(LINE_BYTES);
    localparam int SEG_SH     = $clog2(SEG_BYTES);
endpackage

// File: rtl/coal_chunk_map.sv
// Maps every lane byte address to its aligned chunk address.
// Assumes: mode is stable while the mapped addresses are used.
module coal_chunk_map
    import coal_pkg::*;
#(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic [LANES*AW-1:0] lane_addr,
    input  gran_mode_e          mode,
    output logic [LANES*AW-1:0] chunk_addr
);
    localparam logic [AW-1:0] LINE_MASK = ~((AW'(1) << LINE_SH) - AW'(1));
    localparam logic [AW-1:0] SEG_MASK  = ~((AW'(1) << SEG_SH) - AW'(1));

    logic [AW-1:0] sel_mask;

    // Pick the alignment mask for the current granularity.
    always_comb begin
        sel_mask = (mode == GRAN_LINE) ? LINE_MASK : SEG_MASK;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Clear the offset bits of one lane.
        assign chunk_addr[i*AW +: AW] = lane_addr[i*AW +: AW] & sel_mask;
    end
endmodule

// File: rtl/coal_min_pick.sv
// Balanced tree that finds the smallest chunk address among pending lanes.
// Assumes: LANES is a power of two.
module coal_min_pick #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic [LANES*AW-1:0] chunk_addr,
    input  logic [LANES-1:0]    pend,
    output logic                any_pend,
    output logic [AW-1:0]       min_addr
);
    localparam int NODES = 2 * LANES;

    logic [AW-1:0] node_val [1:NODES-1];
    logic          node_ok  [1:NODES-1];

    for (genvar i = 0; i < LANES; i++) begin : g_leaf
        // Leaf carries one lane and whether it is still pending.
        assign node_val[LANES+i] = chunk_addr[i*AW +: AW];
        assign node_ok[LANES+i]  = pend[i];
    end

    for (genvar k = 1; k < LANES; k++) begin : g_node
        logic take_left;
        // Keep the smaller of two valid children.
        assign take_left   = node_ok[2*k] &&
                             (!node_ok[2*k+1] || node_val[2*k] <= node_val[2*k+1]);
        assign node_val[k] = take_left ? node_val[2*k] : node_val[2*k+1];
        assign node_ok[k]  = node_ok[2*k] | node_ok[2*k+1];
    end

    assign any_pend = node_ok[1];
    assign min_addr = node_val[1];
endmodule

// File: rtl/coal_warp_coalescer.sv
// Warp load coalescer: captures one warp, issues each distinct aligned chunk
// once in ascending order, then pulses done with count and bytes.
// Assumes: req_ready may stall arbitrarily; a warp is never dropped.
module coal_warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES = 32,
    parameter int AW    = 32,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  warp_valid,
    output logic                  warp_ready,
    input  logic                  warp_mode,
    input  logic [LANES-1:0]      warp_active,
    input  logic [LANES*AW-1:0]   warp_addr,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [AW-1:0]         req_addr,
    output logic [7:0]            req_bytes,
    output logic [CNT_W-1:0]      req_seq,
    output logic                  done,
    output logic [CNT_W-1:0]      done_count,
    output logic [CNT_W+6:0]      done_bytes
);
    localparam int BYTES_W = CNT_W + LINE_SH;

    logic                busy_q;
    gran_mode_e          mode_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [LANES*AW-1:0] chunk;
    logic                any_pend;
    logic [AW-1:0]       min_addr;
    logic [LANES-1:0]    hit;
    logic                warp_hs;
    logic                req_hs;

    coal_chunk_map #(.LANES(LANES), .AW(AW)) u_map (
        .lane_addr (addr_q),
        .mode      (mode_q),
        .chunk_addr(chunk)
    );

    coal_min_pick #(.LANES(LANES), .AW(AW)) u_pick (
        .chunk_addr(chunk),
        .pend      (pend_q),
        .any_pend  (any_pend),
        .min_addr  (min_addr)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_hit
        // Lane is covered by the chunk now on the bus.
        assign hit[i] = pend_q[i] && (chunk[i*AW +: AW] == min_addr);
    end

    assign warp_ready = !busy_q;
    assign warp_hs    = warp_valid && warp_ready;
    assign req_valid  = busy_q && any_pend;
    assign req_hs     = req_valid && req_ready;
    assign req_addr   = min_addr;
    assign req_bytes  = (mode_q == GRAN_LINE) ? 8'(LINE_BYTES) : 8'(SEG_BYTES);
    assign req_seq    = cnt_q;
    assign done       = busy_q && !any_pend;
    assign done_count = cnt_q;

    // Scale the request count by the chunk size.
    always_comb begin
        if (mode_q == GRAN_LINE) begin
            done_bytes = BYTES_W'(cnt_q) << LINE_SH;
        end else begin
            done_bytes = BYTES_W'(cnt_q) << SEG_SH;
        end
    end

    // Warp capture, per-chunk retirement and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            mode_q <= GRAN_LINE;
            addr_q <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
        end else if (warp_hs) begin
            busy_q <= 1'b1;
            mode_q <= gran_mode_e'(warp_mode);
            addr_q <= warp_addr;
            pend_q <= warp_active;
            cnt_q  <= '0;
        end else if (req_hs) begin
            pend_q <= pend_q & ~hit;
            cnt_q  <= cnt_q + CNT_W'(1);
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/coal_warp_coalescer_chk.sv
// Protocol and ordering checker for the coalescer, bound to the top.
// Assumes: observes top-level ports only, plus its own shadow registers.
module coal_warp_coalescer_chk #(
    parameter int LANES = 32,
    parameter int AW    = 32,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                warp_valid,
    input logic                warp_ready,
    input logic                req_valid,
    input logic                req_ready,
    input logic [AW-1:0]       req_addr,
    input logic [7:0]          req_bytes,
    input logic                done,
    input logic [CNT_W-1:0]    done_count
);
    logic [AW-1:0]    last_addr;
    logic [CNT_W-1:0] hs_cnt;

    // Shadow count and last address of handshaken requests in this warp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            hs_cnt    <= '0;
        end else if (warp_valid && warp_ready) begin
            hs_cnt    <= '0;
        end else if (req_valid && req_ready) begin
            last_addr <= req_addr;
            hs_cnt    <= hs_cnt + CNT_W'(1);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R7

    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hs_cnt != '0) |-> (req_addr > last_addr)); // R4

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_addr & AW'(req_bytes - 8'd1)) == '0)); // R1

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_bytes == 8'd128 || req_bytes == 8'd32)); // R2

    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || done) |-> !warp_ready); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count == hs_cnt)); // R3
endmodule

bind coal_warp_coalescer coal_warp_coalescer_chk #(
    .LANES(LANES), .AW(AW), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .warp_valid(warp_valid),
    .warp_ready(warp_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_bytes (req_bytes),
    .done      (done),
    .done_count(done_count)
);

// File: tb/coal_warp_coalescer_tb.sv
// Self-checking bench: directed corner warps plus seeded random warps.
module coal_warp_coalescer_tb;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int CNT_W = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                warp_valid = 1'b0;
    logic                warp_ready;
    logic                warp_mode = 1'b0;
    logic [LANES-1:0]    warp_active = '0;
    logic [LANES*AW-1:0] warp_addr = '0;
    logic                req_valid;
    logic                req_ready = 1'b0;
    logic [AW-1:0]       req_addr;
    logic [7:0]          req_bytes;
    logic [CNT_W-1:0]    req_seq;
    logic                done;
    logic [CNT_W-1:0]    done_count;
    logic [CNT_W+6:0]    done_bytes;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [AW-1:0] la [LANES];
    logic [AW-1:0] ex [LANES];
    int            exn;

    coal_warp_coalescer #(.LANES(LANES), .AW(AW), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_ready(warp_ready),
        .warp_mode(warp_mode), .warp_active(warp_active), .warp_addr(warp_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_seq(req_seq), .done(done),
        .done_count(done_count), .done_bytes(done_bytes)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "R6", "watchdog", cycles, 150000);
            summary();
        end
    end

    // Expected unique chunks, sorted ascending, from la[] and warp_active.
    task automatic model(input logic mode);
        logic [AW-1:0] msk;
        logic [AW-1:0] c;
        bit dup;
        msk = mode ? ~32'h1f : ~32'h7f;
        exn = 0;
        for (int i = 0; i < LANES; i++) begin
            if (warp_active[i]) begin
                c = la[i] & msk;
                dup = 0;
                for (int j = 0; j < exn; j++) if (ex[j] == c) dup = 1;
                if (!dup) begin
                    int p;
                    p = exn;
                    while (p > 0 && ex[p-1] > c) begin
                        ex[p] = ex[p-1];
                        p--;
                    end
                    ex[p] = c;
                    exn++;
                end
            end
        end
    endtask

    task automatic run_warp(input logic mode, input int want_n, input int bp);
        int k;
        int guard;
        bit stalled;
        logic [AW-1:0] held;
        for (int i = 0; i < LANES; i++) warp_addr[i*AW +: AW] = la[i];
        warp_mode = mode;
        model(mode);
        if (want_n >= 0) chk(exn == want_n, "R3", "bench model count", exn, want_n);
        guard = 0;
        @(negedge clk);
        while (!warp_ready && guard < 50) begin
            guard++;
            @(negedge clk);
        end
        chk(warp_ready, "R6", "idle before new warp", warp_ready, 1);
        warp_valid = 1'b1;
        @(negedge clk);
        warp_valid = 1'b0;
        chk(!warp_ready, "R6", "not ready after accept", warp_ready, 0);
        k = 0;
        stalled = 0;
        held = '0;
        guard = 0;
        while (guard < 300) begin
            guard++;
            if (done) begin
                chk(!req_valid, "R8", "no request with done", req_valid, 0);
                chk(done_count == CNT_W'(k), "R8", "done_count", done_count, k);
                chk(k == exn, "R3", "request total", k, exn);
                chk(done_bytes == 13'(k * (mode ? 32 : 128)), "R8", "done_bytes",
                    done_bytes, k * (mode ? 32 : 128));
                if (want_n >= 0)
                    chk(done_count == CNT_W'(want_n), "R3", "directed count", done_count, want_n);
                req_ready = 1'b0;
                @(negedge clk);
                chk(!done, "R8", "done one cycle", done, 0);
                chk(warp_ready, "R6", "ready after done", warp_ready, 1);
                return;
            end
            if (stalled)
                chk(req_valid && req_addr == held, "R7", "stall hold", req_addr, held);
            if (req_valid) begin
                chk(!warp_ready, "R6", "busy while issuing", warp_ready, 0);
                if (k < exn) begin
                    chk(req_addr == ex[k], mode ? "R2" : "R1", "req_addr", req_addr, ex[k]);
                    chk(req_bytes == (mode ? 8'd32 : 8'd128), mode ? "R2" : "R1",
                        "req_bytes", req_bytes, mode ? 32 : 128);
                    chk(req_seq == CNT_W'(k), "R8", "req_seq", req_seq, k);
                end else begin
                    chk(1'b0, "R5", "extra request", req_addr, 0);
                end
                req_ready = (bp == 0) ? 1'b1 : (($urandom % 4) != 0);
                stalled = !req_ready;
                held = req_addr;
                if (req_ready) k++;
            end else begin
                req_ready = 1'b0;
                stalled = 0;
            end
            @(negedge clk);
        end
        chk(1'b0, "R8", "done never seen", k, exn);
        req_ready = 1'b0;
    endtask

    initial begin
        logic [AW-1:0] base;
        void'($urandom(32'h5eed_0c0a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(warp_ready, "R10", "warp_ready after reset", warp_ready, 1);
        chk(!req_valid, "R10", "req_valid after reset", req_valid, 0);
        chk(!done, "R10", "done after reset", done, 0);

        // R3 aligned consecutive words
        warp_active = '1;
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_1000 + 32'(i * 4);
        run_warp(1'b0, 1, 0);
        run_warp(1'b1, 4, 1);
        // R3 misaligned by one word
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_2004 + 32'(i * 4);
        run_warp(1'b0, 2, 1);
        run_warp(1'b1, 5, 1);
        // R3 broadcast word
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_3344;
        run_warp(1'b0, 1, 0);
        run_warp(1'b1, 1, 0);
        // R9 reversed lanes, same result as ordered
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_2004 + 32'((LANES - 1 - i) * 4);
        run_warp(1'b0, 2, 1);
        run_warp(1'b1, 5, 1);
        // R5 no active lanes
        warp_active = '0;
        run_warp(1'b0, 0, 0);
        // R5 inactive lanes with stray addresses add nothing
        for (int i = 0; i < LANES; i++)
            la[i] = (i % 2 == 0) ? 32'h0000_4000 + 32'(i * 4) : 32'h00F0_0000 + 32'(i * 256);
        warp_active = 32'h5555_5555;
        run_warp(1'b0, 1, 1);
        run_warp(1'b1, 4, 1);

        // R4 random clustered warps with backpressure
        for (int w = 0; w < 60; w++) begin
            base = $urandom & 32'hFFFF_F000;
            for (int i = 0; i < LANES; i++) la[i] = base + (($urandom % 1024) & 32'h3FC);
            warp_active = (w % 5 == 0) ? '1 : $urandom;
            run_warp(1'($urandom % 2), -1, 1);
        end
        summary();
    end
endmodule